// File: doc/BRIEF.md
# Elastic Buffer Read-Back Self-Test Monitor

This block watches an elastic buffer from outside and checks that one chosen bit comes back out of it intact. A diagnostic trigger pulse takes a snapshot of the buffer's present write address and of the data bit being written there. The monitor then waits one read clock before it starts looking at the read side. From then on it compares every read address with the snapshot.

When the read pointer arrives at the captured slot, the monitor notes the equality in a register. On the following read clock it compares the bit the buffer delivers against the captured bit. A one-cycle strobe reports that the comparison took place, and a flag reports whether the two bits differed. Each trigger gives exactly one comparison; after it the monitor is idle until the next trigger.

All logic runs on the read clock. The buffer is assumed to deliver the data for a read address one read clock after that address is presented. The buffer itself is not part of this block.

Top module: `diag_readback_checker`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `done_o` and `mismatch_o` are 0, and no comparison is pending.
- R2: On a clock edge where `trig_i` is 1, the monitor captures `wr_addr_i` and `wr_bit_i`. Values on those inputs at any later edge have no effect on the comparison started by that trigger.
- R3: Address matching is enabled only from the second clock edge after the trigger edge. A read address equal to the captured one that is present only on the first edge after the trigger is ignored.
- R4: If an enabled comparison sees `rd_addr_i` equal to the captured address at edge k, and no trigger arrives at edge k+1, then `done_o` is 1 for exactly the one cycle that follows edge k+1.
- R5: At edge k+1, `rd_bit_i` is compared with the captured bit. If they differ, `mismatch_o` becomes 1 in the same cycle as the `done_o` pulse. If they are equal, `mismatch_o` stays 0.
- R6: `mismatch_o` is sticky. It changes only on a trigger edge, where it is cleared, on reset, or at an evaluation that finds a difference.
- R7: Only one comparison happens per trigger. After the `done_o` pulse, later matching read addresses produce no further pulse until a new trigger arrives.
- R8: A trigger that arrives while a comparison is waiting, searching or about to evaluate discards that comparison without a `done_o` pulse. It re-captures the address and bit, clears `mismatch_o`, and restarts the sequence of R3.
- R9: Without a trigger since reset or since the last evaluation, `done_o` stays 0 whatever the read address does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_addr_i | input | ADDR_W | Buffer write address at present |
| wr_bit_i | input | 1 | Data bit being written at `wr_addr_i` |
| trig_i | input | 1 | Diagnostic trigger, sampled on each read clock |
| rd_addr_i | input | ADDR_W | Buffer read address at present |
| rd_bit_i | input | 1 | Buffer output bit, for the address presented one clock earlier |
| done_o | output | 1 | One-cycle strobe when a comparison is evaluated |
| mismatch_o | output | 1 | Sticky flag: the last evaluated bit differed |

## Verification
The assertions take for granted that the trigger and all address and data inputs are synchronous to the read clock and stable at its rising edge. They also take for granted that `rd_bit_i` belongs to the address presented one edge earlier. The bench drives every input half a period away from the rising edge. It models the one-clock read latency by choosing `rd_bit_i` on purpose in the cycle after a match. Triggers are placed both in idle periods and in each pending stage, so the assertions on restart and stickiness are exercised under legal timing.

// File: rtl/diag_readback_checker.sv
module diag_readback_checker #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_bit_i,
  output logic              done_o,
  output logic              mismatch_o
);

  logic [ADDR_W-1:0] snap_addr;
  logic              snap_bit;
  logic              pend_q;
  logic              armed_q;
  logic              hit_q;

  wire addr_eq   = armed_q && (rd_addr_i == snap_addr);
  wire eval_now  = hit_q && !trig_i;
  wire bit_error = rd_bit_i ^ snap_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_addr  <= '0;
      snap_bit   <= 1'b0;
      pend_q     <= 1'b0;
      armed_q    <= 1'b0;
      hit_q      <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else if (trig_i) begin
      snap_addr  <= wr_addr_i;
      snap_bit   <= wr_bit_i;
      pend_q     <= 1'b1;
      armed_q    <= 1'b0;
      hit_q      <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      pend_q  <= 1'b0;
      armed_q <= pend_q || (armed_q && !addr_eq);
      hit_q   <= addr_eq;
      done_o  <= eval_now;
      if (eval_now && bit_error)
        mismatch_o <= 1'b1;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  eval_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !trig_i) |=> done_o);

  // R3
  arm_after_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(pend_q));

  // R7
  single_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !armed_q && !hit_q && !pend_q);

  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !hit_q) |=> $stable(mismatch_o));

  // R8
  retrigger_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> !done_o && !mismatch_o && pend_q);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !armed_q && !hit_q && !trig_i) |=> !done_o);

endmodule

// File: tb/diag_readback_checker_tb.sv
module diag_readback_checker_tb_top;
  localparam int AW = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic wr_bit = 1'b0, trig = 1'b0, rd_bit = 1'b0;
  logic done, mismatch;

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference: 0 idle, 1 waiting one clock, 2 searching, 3 evaluate next
  int m_phase = 0;
  int m_addr = 0;
  int m_bit = 0;
  int e_done = 0;
  int e_mis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  diag_readback_checker #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_addr_i(wr_addr), .wr_bit_i(wr_bit),
    .trig_i(trig), .rd_addr_i(rd_addr), .rd_bit_i(rd_bit),
    .done_o(done), .mismatch_o(mismatch)
  );

  task automatic check(input string tag);
    n_checks++;
    if (done !== e_done[0] || mismatch !== e_mis[0]) begin
      n_fail++;
      $display("FAIL %s: done=%b mismatch=%b expected done=%0d mismatch=%0d at %0t",
               tag, done, mismatch, e_done, e_mis, $time);
    end
  endtask

  task automatic model_edge(input int t, input int wa, input int wb, input int ra, input int rb);
    e_done = 0;
    if (t != 0) begin
      m_addr = wa; m_bit = wb; m_phase = 1; e_mis = 0;
    end else begin
      case (m_phase)
        1: m_phase = 2;
        2: if (ra == m_addr) m_phase = 3;
        3: begin
          e_done = 1;
          if (rb != m_bit) e_mis = 1;
          m_phase = 0;
        end
        default: m_phase = 0;
      endcase
    end
  endtask

  task automatic step(input bit t, input int wa, input bit wb, input int ra, input bit rb,
                      input string tag);
    trig = t; wr_addr = wa[AW-1:0]; wr_bit = wb; rd_addr = ra[AW-1:0]; rd_bit = rb;
    @(posedge clk);
    model_edge(t, wa, wb, ra, rb);
    #1;
    check(tag);
    #(CLK_PERIOD/2 - 1);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0; trig = 0;
    m_phase = 0; e_done = 0; e_mis = 0;
    #1; check(tag);
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/2);
    check(tag);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/2 + 2);
    do_reset("R1 reset state");

    // R9: no trigger, sweep all read addresses
    for (int a = 0; a < 16; a++) step(0, a, 1, a, a % 2, "R9 no trigger");

    // R2/R3/R4/R5: capture addr 5 bit 1, matched with equal data
    step(1, 5, 1, 0, 0, "R2 trigger");
    step(0, 2, 0, 5, 0, "R3 match ignored first edge");
    step(0, 6, 0, 6, 0, "R2 later write values");
    step(0, 7, 0, 5, 0, "R4 equality");
    step(0, 8, 0, 6, 1, "R4 R5 evaluation equal");
    step(0, 9, 0, 7, 0, "R4 strobe one cycle");

    // R5/R6/R7: capture addr 9 bit 0, read back 1
    step(1, 9, 0, 1, 0, "R2 trigger");
    step(0, 9, 1, 2, 0, "R3 waiting");
    step(0, 9, 1, 3, 0, "R3 searching");
    step(0, 9, 1, 9, 1, "R4 equality");
    step(0, 9, 1, 10, 1, "R5 evaluation differs");
    for (int i = 0; i < 20; i++) step(0, i, 1, (i + 9) % 16, 1, "R6 R7 sticky no second compare");

    // R8: retrigger while evaluation is due
    step(1, 3, 1, 0, 0, "R8 trigger");
    step(0, 0, 0, 0, 0, "R8 waiting");
    step(0, 0, 0, 3, 0, "R8 equality");
    step(1, 7, 0, 4, 1, "R8 retrigger cancels evaluation");
    step(0, 0, 1, 7, 1, "R3 R8 restart ignored first edge");
    step(0, 0, 1, 7, 1, "R8 equality after restart");
    step(0, 0, 1, 0, 1, "R8 evaluation differs");
    step(0, 0, 1, 0, 1, "R6 sticky");
    // retrigger during waiting and searching stages
    step(1, 12, 1, 0, 0, "R8 trigger");
    step(1, 13, 0, 12, 1, "R8 retrigger while waiting");
    step(0, 0, 0, 1, 0, "R8 waiting");
    step(0, 0, 0, 12, 1, "R8 stale address ignored");
    step(1, 14, 1, 12, 0, "R8 retrigger while searching");
    step(0, 0, 0, 14, 0, "R3 waiting");
    step(0, 0, 0, 13, 0, "R8 searching");
    step(0, 0, 0, 14, 0, "R4 equality");
    step(0, 0, 0, 14, 1, "R5 evaluation equal");

    // R6: reset clears sticky flag
    step(1, 1, 1, 0, 0, "R2 trigger");
    step(0, 0, 0, 0, 0, "R3 waiting");
    step(0, 0, 0, 1, 0, "R4 equality");
    step(0, 0, 0, 0, 0, "R5 evaluation differs");
    step(0, 0, 0, 0, 0, "R6 sticky");
    do_reset("R1 R6 reset clears flag");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      automatic bit t = ($urandom % 23) == 0;
      step(t, $urandom % 16, $urandom % 2, $urandom % 16, $urandom % 2, "R4 R5 R8 mixed");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule